// File: doc/BRIEF.md
# Capture/Compare Channel with PWM Output

One channel of a multi-channel timer. The channel watches a free-running 16-bit count value that is shared with its sibling channels. It drives one output pin and keeps one 16-bit capture/compare register. A mode input selects one of six behaviours:
- edge-triggered capture of the count on a pin transition;
- a software timer that raises a flag on a match;
- toggle-on-match output;
- a divided square wave from a channel-local counter;
- pulse-width modulation at a selectable resolution of 8 to 11 bits;
- pulse-width modulation at the full 16 bits.

Every PWM setting runs edge-aligned or center-aligned.

The count advances only on cycles where the shared enable tick is high, and all timing in the channel is evaluated on those ticks. Capture is the exception: it runs on the synchronized pin at any cycle. In the PWM modes, a write to the register fills a shadow. The shadow becomes the live compare value only at the start of a PWM period, so a duty change never cuts a pulse short.

The output stage first applies a kill from an external comparator. The kill forces the output inactive at once, and it stays in force until the next period start after the comparator releases. A programmable polarity inversion is applied last. All ports are plain control and status signals; the channel has no streaming interface, so no valid/ready handshake or back-pressure applies.

Top module: `ccc_channel`

## Requirements
- R1: After reset ccr_o is 0, flag_o is 0 and pin_o equals invert_i. Modes 6 and 7 hold the output inactive and never set the flag.
- R2: In mode 1 (timer), flag_o is 1 in the cycle after a tick on which cnt_i equals ccr_o. A match without a tick has no effect. flag_clr_i clears the flag, and a new set in the same cycle wins over the clear.
- R3: In mode 2 (toggle), the active level inverts in the cycle after each ticked match of cnt_i with ccr_o, and flag_o is set. It starts inactive on entry to the mode.
- R4: In mode 3 (frequency), the active level inverts after every D+1 ticks, where D = ccr_o[7:0]. It starts inactive on entry to the mode, and cycles without a tick do not advance it.
- R5: In mode 0 (capture), a pin_i edge of an enabled kind (rising with capt_rise_i, falling with capt_fall_i) loads cnt_i into ccr_o and sets flag_o 3 clock cycles after pin_i changes (two-flop synchronizer). Edges of a disabled kind leave ccr_o and flag_o unchanged.
- R6: In mode 4, edge-aligned (center_i=0), with N = 8 + pwm_bits_i, the active level after a tick is (cnt_i[N-1:0] < compare). The upper bits of cnt_i are ignored, and a compare of 2^N or more gives a constant active level.
- R7: In mode 5, edge-aligned, the active level after a tick is (cnt_i < compare) over all 16 bits.
- R8: With center_i=1 in mode 4 or 5, the position is a channel-local count. It starts at 0 on entry, runs up to 2^N-1, then back down to 0, and repeats. The active level after a tick is (position < compare), and cnt_i is ignored.
- R9: In PWM modes the compare value is replaced by ccr_o only on a tick where the position is 0. ccr_o itself follows a write (ccr_wr_i) in the next cycle in every mode.
- R10: While kill_en_i and cmp_kill_i are both 1, the output is inactive in the same cycle. In PWM modes it stays inactive until the first tick with position 0 at which the kill is released. With kill_en_i=0, cmp_kill_i has no effect.
- R11: pin_o is the active level after kill, XORed with invert_i, so a killed output reads as invert_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Shared count value |
| tick_i | input | 1 | Count enable; channel timing advances on it |
| mode_i | input | 3 | Mode select (0 capture, 1 timer, 2 toggle, 3 frequency, 4 PWM 8-11 bit, 5 PWM 16 bit, 6/7 off) |
| pwm_bits_i | input | 2 | PWM resolution in mode 4: 8 + value bits |
| center_i | input | 1 | 1 selects center-aligned PWM |
| capt_rise_i | input | 1 | Capture on rising pin edge |
| capt_fall_i | input | 1 | Capture on falling pin edge |
| pin_i | input | 1 | Asynchronous pin for capture |
| invert_i | input | 1 | Output polarity inversion |
| kill_en_i | input | 1 | Enables comparator kill |
| cmp_kill_i | input | 1 | Comparator kill request |
| ccr_wr_i | input | 1 | Write strobe for the capture/compare register |
| ccr_wdata_i | input | 16 | Write data |
| flag_clr_i | input | 1 | Clears the match/capture flag |
| pin_o | output | 1 | Channel output |
| ccr_o | output | 16 | Capture/compare register |
| flag_o | output | 1 | Match/capture flag |

## Verification
The assertions assume that pin_i is low while reset is asserted, so that the zeroed synchronizer does not report a false edge. They also assume that mode_i changes only after a cycle in an off mode, which restarts the toggle, frequency and center-aligned state from a known point. The stimulus keeps to both assumptions: every scenario enters through mode 7, and pin_i only moves during capture tests. Register writes are issued with the tick low, except the mid-period writes that probe the shadow reload.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  typedef enum logic [2:0] {
    MD_CAPTURE  = 3'd0,
    MD_TIMER    = 3'd1,
    MD_TOGGLE   = 3'd2,
    MD_FREQ     = 3'd3,
    MD_PWM_N    = 3'd4,
    MD_PWM_FULL = 3'd5,
    MD_OFF_A    = 3'd6,
    MD_OFF_B    = 3'd7
  } ccc_mode_e;

  localparam int unsigned PWM_MIN_BITS = 8;
endpackage

// File: rtl/ccc_edge_sync.sv
module ccc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic rise_o,
  output logic fall_o
);
  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], din_i};
  end

  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

  p_rise_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> $past(din_i, STAGES));
  p_fall_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !$past(din_i, STAGES));
endmodule

// File: rtl/ccc_freq_gen.sv
module ccc_freq_gen #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [DW-1:0] div_i,
  output logic          wave_o
);
  logic [DW-1:0] div_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt_q <= '0;
      wave_o    <= 1'b0;
    end else if (!run_i) begin
      div_cnt_q <= '0;
      wave_o    <= 1'b0;
    end else if (tick_i) begin
      if (div_cnt_q == div_i) begin
        div_cnt_q <= '0;
        wave_o    <= ~wave_o;
      end else begin
        div_cnt_q <= div_cnt_q + 1'b1;
      end
    end
  end

  p_freq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !(tick_i && div_cnt_q == div_i)) |=> $stable(wave_o));
endmodule

// File: rtl/ccc_pwm_core.sv
module ccc_pwm_core #(
  parameter int unsigned CW   = 16,
  parameter int unsigned NMIN = 8,
  parameter int unsigned SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            full_i,
  input  logic            center_i,
  input  logic            tick_i,
  input  logic [SELW-1:0] bits_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic [CW-1:0]   shadow_i,
  output logic            active_o,
  output logic            start_o
);
  logic [CW-1:0] lim;
  logic [CW-1:0] pos;
  logic [CW-1:0] cmp_q;
  logic [CW-1:0] cmp_eff;
  logic [CW-1:0] ramp_q;
  logic          up_q;
  logic          center_run;

  always_comb begin
    if (full_i) lim = '1;
    else        lim = (CW'(1) << (NMIN + 32'(bits_i))) - CW'(1);
  end

  assign center_run = run_i & center_i;
  assign pos        = center_run ? ramp_q : (cnt_i & lim);
  assign start_o    = run_i & tick_i & (pos == '0);
  assign cmp_eff    = start_o ? shadow_i : cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      active_o <= 1'b0;
    end else begin
      cmp_q <= cmp_eff;
      if (!run_i)      active_o <= 1'b0;
      else if (tick_i) active_o <= (pos < cmp_eff);
    end
  end

  // channel-local up/down position for center-aligned operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
      up_q   <= 1'b1;
    end else if (!center_run) begin
      ramp_q <= '0;
      up_q   <= 1'b1;
    end else if (tick_i) begin
      if (up_q) begin
        if (ramp_q >= lim) begin
          up_q   <= 1'b0;
          ramp_q <= ramp_q - 1'b1;
        end else begin
          ramp_q <= ramp_q + 1'b1;
        end
      end else begin
        if (ramp_q == '0) begin
          up_q   <= 1'b1;
          ramp_q <= ramp_q + 1'b1;
        end else begin
          ramp_q <= ramp_q - 1'b1;
        end
      end
    end
  end

  p_ramp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (center_run && tick_i) |=>
      (!center_run || ramp_q == $past(ramp_q) + 1'b1 || ramp_q == $past(ramp_q) - 1'b1));
  p_ramp_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (center_run && start_o) |=> (!center_run || ramp_q == CW'(1)));
  p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !active_o);
endmodule

// File: rtl/ccc_channel.sv
module ccc_channel
  import ccc_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned FDW      = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          tick_i,
  input  logic [2:0]    mode_i,
  input  logic [1:0]    pwm_bits_i,
  input  logic          center_i,
  input  logic          capt_rise_i,
  input  logic          capt_fall_i,
  input  logic          pin_i,
  input  logic          invert_i,
  input  logic          kill_en_i,
  input  logic          cmp_kill_i,
  input  logic          ccr_wr_i,
  input  logic [CW-1:0] ccr_wdata_i,
  input  logic          flag_clr_i,
  output logic          pin_o,
  output logic [CW-1:0] ccr_o,
  output logic          flag_o
);
  ccc_mode_e md;
  logic [CW-1:0] ccr_q;
  logic flag_q, tog_q, killed_q;
  logic rise, fall, capt_hit, cmp_hit;
  logic pwm_run, pwm_act, pwm_start, wave;
  logic kill_now, raw_act;

  assign md = ccc_mode_e'(mode_i);

  ccc_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  assign capt_hit = (md == MD_CAPTURE) & ((capt_rise_i & rise) | (capt_fall_i & fall));
  assign cmp_hit  = tick_i & (cnt_i == ccr_q);
  assign pwm_run  = (md == MD_PWM_N) | (md == MD_PWM_FULL);

  ccc_pwm_core #(.CW(CW), .NMIN(PWM_MIN_BITS), .SELW(2)) u_pwm (
    .clk(clk), .rst_n(rst_n), .run_i(pwm_run), .full_i(md == MD_PWM_FULL),
    .center_i(center_i), .tick_i(tick_i), .bits_i(pwm_bits_i), .cnt_i(cnt_i),
    .shadow_i(ccr_q), .active_o(pwm_act), .start_o(pwm_start)
  );

  ccc_freq_gen #(.DW(FDW)) u_freq (
    .clk(clk), .rst_n(rst_n), .run_i(md == MD_FREQ), .tick_i(tick_i),
    .div_i(ccr_q[FDW-1:0]), .wave_o(wave)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q    <= '0;
      flag_q   <= 1'b0;
      tog_q    <= 1'b0;
      killed_q <= 1'b0;
    end else begin
      if (capt_hit)      ccr_q <= cnt_i;
      else if (ccr_wr_i) ccr_q <= ccr_wdata_i;

      if (capt_hit || (cmp_hit && (md == MD_TIMER || md == MD_TOGGLE))) flag_q <= 1'b1;
      else if (flag_clr_i)                                           flag_q <= 1'b0;

      if (md != MD_TOGGLE) tog_q <= 1'b0;
      else if (cmp_hit)    tog_q <= ~tog_q;

      if (!pwm_run)       killed_q <= 1'b0;
      else if (kill_now)  killed_q <= 1'b1;
      else if (pwm_start) killed_q <= 1'b0;
    end
  end

  assign kill_now = kill_en_i & cmp_kill_i;

  always_comb begin
    case (md)
      MD_TOGGLE:              raw_act = tog_q;
      MD_FREQ:                raw_act = wave;
      MD_PWM_N, MD_PWM_FULL:  raw_act = pwm_act;
      default:                raw_act = 1'b0;
    endcase
  end

  assign pin_o  = invert_i ^ (raw_act & ~kill_now & ~killed_q);
  assign ccr_o  = ccr_q;
  assign flag_o = flag_q;

  p_timer_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_TIMER && tick_i && cnt_i == ccr_o) |=> flag_o);
  p_toggle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_TOGGLE && !(tick_i && cnt_i == ccr_o)) |=> $stable(tog_q));
  p_capture_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capt_hit |=> (flag_o && ccr_o == $past(cnt_i)));
  p_kill_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_en_i && cmp_kill_i) |-> (pin_o == invert_i));
  p_kill_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_run && kill_en_i && cmp_kill_i) |=> (!pwm_run || killed_q));
endmodule

// File: tb/tb_ccc_channel.sv
module tb_ccc_channel;
  localparam time HALF = 5ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic tick = 1'b0;
  logic [2:0] mode = 3'd7;
  logic [1:0] bits = '0;
  logic center = 1'b0, rise_en = 1'b0, fall_en = 1'b0, pin_in = 1'b0;
  logic inv = 1'b0, kill_en = 1'b0, cmp_kill = 1'b0;
  logic ccr_wr = 1'b0, flag_clr = 1'b0;
  logic [15:0] ccr_wdata = '0;
  logic pin;
  logic [15:0] ccr;
  logic flag;

  int n_chk = 0, n_err = 0;
  logic [15:0] cur_ccr, cmp_b, c_b, lim_b, pos_b;
  logic killed_b, up_b;

  always #HALF clk = ~clk;

  ccc_channel dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .tick_i(tick), .mode_i(mode),
    .pwm_bits_i(bits), .center_i(center), .capt_rise_i(rise_en), .capt_fall_i(fall_en),
    .pin_i(pin_in), .invert_i(inv), .kill_en_i(kill_en), .cmp_kill_i(cmp_kill),
    .ccr_wr_i(ccr_wr), .ccr_wdata_i(ccr_wdata), .flag_clr_i(flag_clr),
    .pin_o(pin), .ccr_o(ccr), .flag_o(flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ccr(input logic [15:0] v);
    tick = 1'b0; ccr_wr = 1'b1; ccr_wdata = v;
    cyc();
    ccr_wr = 1'b0; cur_ccr = v;
  endtask

  task automatic go_idle();
    mode = 3'd7; tick = 1'b0; cmp_kill = 1'b0; flag_clr = 1'b1;
    cyc(); cyc();
    flag_clr = 1'b0;
  endtask

  function automatic logic [15:0] lim_of(input logic [2:0] m, input logic [1:0] b);
    return (m == 3'd5) ? 16'hFFFF : 16'((32'd1 << (8 + b)) - 1);
  endfunction

  // edge-aligned PWM run with reference model (R6 R7 R9 R10 R11)
  task automatic pwm_edge_run(input int n, input bit jump, input int wr_at, input logic [15:0] wr_val,
                              input int k_on, input int k_off, input string req);
    for (int s = 0; s < n; s++) begin
      logic raw, kn, expv;
      if (jump && s > 0) c_b = ($urandom % 6 == 0) ? 16'd0 : (16'($urandom) & lim_b);
      if (s == k_on)  cmp_kill = 1'b1;
      if (s == k_off) cmp_kill = 1'b0;
      cnt  = (c_b & lim_b) | (16'($urandom) & ~lim_b);
      tick = 1'b1;
      if (s == wr_at) begin ccr_wr = 1'b1; ccr_wdata = wr_val; end
      #1;
      if (kill_en && cmp_kill) chk("R10", {31'd0, pin}, {31'd0, inv}, "kill acts in same cycle");
      cyc();
      ccr_wr = 1'b0;
      if (c_b == 16'd0) cmp_b = cur_ccr;
      raw = (c_b < cmp_b);
      kn  = kill_en & cmp_kill;
      if (kn) killed_b = 1'b1;
      else if (c_b == 16'd0) killed_b = 1'b0;
      expv = inv ^ (raw & ~kn & ~killed_b);
      chk(req, {31'd0, pin}, {31'd0, expv}, "pwm level");
      if (s == wr_at) cur_ccr = wr_val;
      if (!jump) c_b = (c_b + 16'd1) & lim_b;
      if ($urandom % 16 == 0) begin
        tick = 1'b0; cnt = 16'($urandom);
        cyc();
        chk(req, {31'd0, pin}, {31'd0, expv}, "no change without tick");
      end
    end
  endtask

  // center-aligned run (R8 R9)
  task automatic pwm_center_run(input int n, input int wr_at, input logic [15:0] wr_val, input string req);
    for (int s = 0; s < n; s++) begin
      logic expv;
      cnt = 16'($urandom); tick = 1'b1;
      if (s == wr_at) begin ccr_wr = 1'b1; ccr_wdata = wr_val; end
      cyc();
      ccr_wr = 1'b0;
      if (pos_b == 16'd0) cmp_b = cur_ccr;
      expv = inv ^ (pos_b < cmp_b);
      chk(req, {31'd0, pin}, {31'd0, expv}, "center pwm level");
      if (s == wr_at) cur_ccr = wr_val;
      if (up_b) begin
        if (pos_b >= lim_b) begin up_b = 1'b0; pos_b = pos_b - 16'd1; end
        else pos_b = pos_b + 16'd1;
      end else begin
        if (pos_b == 16'd0) begin up_b = 1'b1; pos_b = pos_b + 16'd1; end
        else pos_b = pos_b - 16'd1;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    cur_ccr = '0; cmp_b = '0; c_b = '0; lim_b = 16'h00FF; killed_b = 1'b0;
    pos_b = '0; up_b = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and off modes
    chk("R1", {16'd0, ccr}, 32'd0, "ccr after reset");
    chk("R1", {31'd0, flag}, 32'd0, "flag after reset");
    chk("R1", {31'd0, pin}, 32'd0, "pin after reset");
    inv = 1'b1; #1;
    chk("R1", {31'd0, pin}, 32'd1, "pin follows polarity at reset");
    inv = 1'b0;
    for (int i = 0; i < 4; i++) begin
      mode = (i % 2 == 0) ? 3'd6 : 3'd7; cnt = 16'd0; tick = 1'b1;
      cyc();
      chk("R1", {30'd0, pin, flag}, 32'd0, "off mode output and flag");
    end

    // R2 timer
    go_idle(); set_ccr(16'h1234); mode = 3'd1;
    cnt = 16'h1233; tick = 1'b1; cyc();
    chk("R2", {31'd0, flag}, 32'd0, "no flag before match");
    cnt = 16'h1234; tick = 1'b0; cyc();
    chk("R2", {31'd0, flag}, 32'd0, "match without tick ignored");
    tick = 1'b1; cyc();
    chk("R2", {31'd0, flag}, 32'd1, "flag on ticked match");
    tick = 1'b0; flag_clr = 1'b1; cyc();
    chk("R2", {31'd0, flag}, 32'd0, "flag cleared");
    tick = 1'b1; cyc();
    chk("R2", {31'd0, flag}, 32'd1, "set wins over clear");
    flag_clr = 1'b0;
    for (int i = 0; i < 20; i++) begin
      logic [15:0] r; bit hit;
      r = 16'($urandom); hit = $urandom % 2;
      set_ccr(r);
      flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
      cnt = hit ? r : (r ^ 16'($urandom_range(1, 65535))); tick = 1'b1;
      cyc();
      chk("R2", {31'd0, flag}, {31'd0, hit}, "random timer match");
      chk("R9", {16'd0, ccr}, {16'd0, r}, "ccr follows write");
    end

    // R3 toggle on match
    go_idle(); set_ccr(16'h00A0); mode = 3'd2; #1;
    chk("R3", {31'd0, pin}, 32'd0, "toggle starts inactive");
    begin
      logic tog_b, fl_b;
      tog_b = 1'b0; fl_b = 1'b0;
      for (int i = 0; i < 16; i++) begin
        bit hit, tk;
        hit = $urandom % 2; tk = ($urandom % 4) != 0;
        cnt = hit ? 16'h00A0 : (16'h00A0 ^ 16'($urandom_range(1, 65535))); tick = tk;
        cyc();
        if (hit && tk) begin tog_b = ~tog_b; fl_b = 1'b1; end
        chk("R3", {31'd0, pin}, {31'd0, tog_b}, "toggle level");
        chk("R3", {31'd0, flag}, {31'd0, fl_b}, "toggle flag");
      end
    end

    // R4 frequency output
    for (int k = 0; k < 2; k++) begin
      logic [7:0] d; int t;
      d = (k == 0) ? 8'd3 : 8'($urandom_range(0, 6));
      go_idle(); set_ccr({8'hA5, d}); mode = 3'd3; t = 0;
      for (int i = 0; i < 48; i++) begin
        bit tk;
        tk = ($urandom % 4) != 0; tick = tk; cnt = 16'($urandom);
        cyc();
        if (tk) t++;
        chk("R4", {31'd0, pin}, 32'((t / (int'(d) + 1)) % 2), "frequency level");
      end
    end

    // R5 capture
    go_idle(); mode = 3'd0; rise_en = 1'b1; fall_en = 1'b0;
    cnt = 16'hBEEF; pin_in = 1'b1;
    cyc(); cyc();
    chk("R5", {31'd0, flag}, 32'd0, "no capture before sync delay");
    cyc();
    chk("R5", {16'd0, ccr}, 32'h0000BEEF, "rising capture value");
    chk("R5", {31'd0, flag}, 32'd1, "rising capture flag");
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    cnt = 16'h1111; pin_in = 1'b0;
    repeat (4) cyc();
    chk("R5", {16'd0, ccr}, 32'h0000BEEF, "disabled falling edge ignored");
    chk("R5", {31'd0, flag}, 32'd0, "no flag on disabled edge");
    rise_en = 1'b0; fall_en = 1'b1; cnt = 16'h2222; pin_in = 1'b1;
    repeat (4) cyc();
    chk("R5", {16'd0, ccr}, 32'h0000BEEF, "disabled rising edge ignored");
    cnt = 16'h3333; pin_in = 1'b0;
    repeat (3) cyc();
    chk("R5", {16'd0, ccr}, 32'h00003333, "falling capture value");
    chk("R5", {31'd0, flag}, 32'd1, "falling capture flag");
    fall_en = 1'b0;

    // R6 edge-aligned N-bit, random resolution and polarity
    for (int k = 0; k < 3; k++) begin
      logic [1:0] b;
      b = 2'($urandom_range(0, 3));
      go_idle(); bits = b; center = 1'b0; inv = 1'($urandom % 2);
      lim_b = lim_of(3'd4, b);
      set_ccr(16'($urandom_range(0, int'(lim_b) + 3)));
      mode = 3'd4; c_b = '0; killed_b = 1'b0;
      pwm_edge_run(int'(lim_b) + 40, 1'b0, -1, 16'd0, -1, -1, "R6");
    end

    // R9 shadow reload mid-period
    go_idle(); bits = 2'd0; center = 1'b0; inv = 1'b0; lim_b = 16'h00FF;
    set_ccr(16'd40); mode = 3'd4; c_b = '0;
    pwm_edge_run(600, 1'b0, 356, 16'd200, -1, -1, "R9");

    // R7 full 16-bit with jumping count
    go_idle(); inv = 1'b0; lim_b = 16'hFFFF;
    set_ccr(16'($urandom_range(1000, 64000))); mode = 3'd5; c_b = '0;
    pwm_edge_run(60, 1'b1, -1, 16'd0, -1, -1, "R7");

    // R8 center-aligned, 8 and 9 bits
    for (int k = 0; k < 2; k++) begin
      go_idle(); bits = 2'(k); center = 1'b1; inv = 1'(k);
      lim_b = lim_of(3'd4, 2'(k));
      set_ccr(k == 0 ? 16'd100 : 16'($urandom_range(0, 520)));
      mode = 3'd4; pos_b = '0; up_b = 1'b1;
      pwm_center_run(2 * 2 * int'(lim_b) + 5, (k == 0) ? 300 : -1, 16'd30, "R8");
    end
    center = 1'b0;

    // R10 kill hold, R11 polarity after kill
    for (int k = 0; k < 2; k++) begin
      go_idle(); bits = 2'd0; inv = 1'(k); kill_en = 1'b1; lim_b = 16'h00FF;
      set_ccr(16'd200); mode = 3'd4; c_b = '0; killed_b = 1'b0;
      pwm_edge_run(300, 1'b0, -1, 16'd0, 51, 60, (k == 0) ? "R10" : "R11");
    end
    go_idle(); inv = 1'b0; kill_en = 1'b0; set_ccr(16'd200); mode = 3'd4; c_b = '0;
    pwm_edge_run(80, 1'b0, -1, 16'd0, 20, 40, "R10");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule